// File: doc/BRIEF.md
# Signed-Digit Rounding Decision Unit

This block decides how a floating-point significand held in radix-16 signed digits must be rounded. Each digit carries four positively weighted bits and one negatively weighted redundancy bit. The most significant digit is known to be non-negative, so only its four positive bits enter the block. The rounding position is not fixed. It follows the leading one of the most significant digit and moves one bit lower when a separately computed signed-sticky flag reports that the part below that leading one is negative.

For the chosen IEEE rounding mode and the operand sign, the block classifies the fraction below the rounding position and returns the value to add at that position. The value is one of −1, 0 or +1 and is carried on two mutually exclusive bits. The block is purely combinational. A decision is computed in parallel for every candidate position. The late signed-sticky flag only selects among the finished candidates, so it never passes through the fraction arithmetic.

Top module: `sd_round_decide`

## Requirements
- R1: `lead_o` is one-hot on the most significant set bit of `msd_i`, with `lead_o[3]` standing for the top bit. When `msd_i` is zero, `lead_o`, `loc_o`, `rnd_up_o` and `rnd_dn_o` are all zero.
- R2: With `ss_i` = 0, the rounding location is the LSD bit one place below the leading bit. The encoding is `loc_o[4]` = f (LSD bit 3), `loc_o[3]` = g, `loc_o[2]` = h, `loc_o[1]` = i (LSD bit 0) and `loc_o[0]` = g0. `loc_o` has at most one bit set.
- R3: With `ss_i` = 1, the location moves one bit lower. A leading bit at `msd_i[0]` then selects g0 (`loc_o` = 00001).
- R4: Mode 00 (nearest-even) gives −1 for a fraction below −1/2 and +1 above +1/2. At exactly −1/2 it gives −L, and at exactly +1/2 it gives +L, where L is the bit at the location. Otherwise it gives 0.
- R5: Mode 01 (toward zero) gives −1 whenever the fraction is negative and 0 otherwise. It never gives +1.
- R6: Mode 10 (toward plus) with `sign_i` = 0, and mode 11 (toward minus) with `sign_i` = 1, give +1 for a positive fraction and 0 otherwise. The two remaining sign cases give −1 for a negative fraction and 0 otherwise. The fraction weights the bits below the location as follows: LSD bits below it by their binary place, `gd_neg_i` as −1 and `gd_pos_i` as +1/2 of an i-unit, `rnd_bit_i` as +1/4, `st_neg_i` as −1/4, and `st_pos_i` as +1/8.
- R7: At the g0 location, the fraction is formed from `rnd_bit_i`, `st_neg_i` and `st_pos_i` only, and L is `gd_pos_i`.
- R8: The output value is `rnd_up_o` − `rnd_dn_o`. The two bits are never both 1.
- R9: The negative LSD bit e (`lsd_i[4]`), and the LSD bits above the location, do not change the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| msd_i | input | 4 | Positive bits of the most significant digit, bit 3 highest |
| lsd_i | input | 5 | Least significant digit: bit 4 = e (negative weight), bits 3..0 = f, g, h, i |
| gd_neg_i | input | 1 | Negatively weighted guard bit (g1) |
| gd_pos_i | input | 1 | Positively weighted guard bit (g0) |
| rnd_bit_i | input | 1 | Round bit |
| st_neg_i | input | 1 | Negatively weighted sticky bit (s1) |
| st_pos_i | input | 1 | Positively weighted sticky bit (s0) |
| ss_i | input | 1 | Signed sticky: the part below the leading one is negative |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward plus, 11 toward minus |
| sign_i | input | 1 | Operand sign, 1 = negative |
| lead_o | output | 4 | One-hot leading bit of the MSD |
| loc_o | output | 5 | One-hot rounding location (f, g, h, i, g0 from bit 4 down) |
| rnd_up_o | output | 1 | Rounding value includes +1 |
| rnd_dn_o | output | 1 | Rounding value includes −1 |

## Verification
The block holds no state, so any wrong internal value appears at the ports in the same cycle the inputs are applied. Typical faults are a mis-weighted tail bit, a candidate decided at the wrong position, or a select driven by the wrong signed-sticky polarity. These show up as a wrong `loc_o` or as a wrong up/down pair, most often on exact half-way fractions and on the g0 and i positions, where the negatively weighted bits matter. A behavioural model compares every port on every clock over directed tie and sign cases and a large random sweep. A pairwise probe confirms that the e bit and the bits above the location leave the decision unchanged.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_PLUS   = 2'b10,
        RM_TO_MINUS  = 2'b11
    } rnd_mode_e;

    // Classification of the fraction below a candidate rounding position
    typedef struct packed {
        logic below_nhalf;   // fraction < -1/2
        logic at_nhalf;      // fraction == -1/2
        logic negative;      // fraction < 0
        logic positive;      // fraction > 0
        logic at_phalf;      // fraction == +1/2
        logic above_phalf;   // fraction > +1/2
    } frac_cls_t;

endpackage

// File: rtl/sdr_lead_detect.sv
module sdr_lead_detect #(
    parameter int NPOS = 4
) (
    input  logic [NPOS-1:0] msd_i,
    input  logic            ss_i,
    output logic [NPOS-1:0] lead_o,
    output logic [NPOS:0]   loc_o
);

    logic found;

    // Priority scan from the top bit of the MSD
    always_comb begin
        lead_o = '0;
        found  = 1'b0;
        for (int k = NPOS - 1; k >= 0; k--) begin
            if (!found && msd_i[k]) begin
                lead_o[k] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    // Signed sticky lowers the location by one place
    always_comb begin
        if (ss_i) begin
            loc_o = {1'b0, lead_o};
        end else begin
            loc_o = {lead_o, 1'b0};
        end
    end

endmodule

// File: rtl/sdr_frac_class.sv
module sdr_frac_class
    import sdr_pkg::*;
#(
    parameter int NPOS = 4,
    parameter int LOC  = 0
) (
    input  logic [NPOS:0] lsd_i,
    input  logic [4:0]    tail_i,   // {g1, g0, r, s1, s0}
    output frac_cls_t     cls_o,
    output logic          lbit_o
);

    // Scale: bit i of the LSD weighs 8; location LOC weighs 4 << LOC
    localparam int HALF = 2 << LOC;

    int below;

    always_comb begin
        below = 0;
        for (int j = 0; j <= NPOS; j++) begin
            if ((j + 1 < LOC) && lsd_i[j]) begin
                below = below + ((j == NPOS) ? -(8 << j) : (8 << j));
            end
        end
        if ((LOC >= 1) && tail_i[4]) below = below - 8;
        if ((LOC >= 1) && tail_i[3]) below = below + 4;
        if (tail_i[2]) below = below + 2;
        if (tail_i[1]) below = below - 2;
        if (tail_i[0]) below = below + 1;
    end

    always_comb begin
        cls_o.below_nhalf = (below < -HALF);
        cls_o.at_nhalf    = (below == -HALF);
        cls_o.negative    = (below < 0);
        cls_o.positive    = (below > 0);
        cls_o.at_phalf    = (below == HALF);
        cls_o.above_phalf = (below > HALF);
    end

    generate
        if (LOC == 0) begin : g_at_guard
            assign lbit_o = tail_i[3];
        end else begin : g_at_lsd
            assign lbit_o = lsd_i[LOC-1];
        end
    endgenerate

endmodule

// File: rtl/sdr_mode_decide.sv
module sdr_mode_decide
    import sdr_pkg::*;
(
    input  frac_cls_t cls_i,
    input  logic      lbit_i,
    input  rnd_mode_e mode_i,
    input  logic      sign_i,
    output logic      up_o,
    output logic      dn_o
);

    always_comb begin
        up_o = 1'b0;
        dn_o = 1'b0;
        unique case (mode_i)
            RM_NEAR_EVEN: begin
                up_o = cls_i.above_phalf | (cls_i.at_phalf & lbit_i);
                dn_o = cls_i.below_nhalf | (cls_i.at_nhalf & lbit_i);
            end
            RM_TO_ZERO: begin
                dn_o = cls_i.negative;
            end
            RM_TO_PLUS: begin
                if (sign_i) dn_o = cls_i.negative;
                else        up_o = cls_i.positive;
            end
            RM_TO_MINUS: begin
                if (sign_i) up_o = cls_i.positive;
                else        dn_o = cls_i.negative;
            end
            default: begin
                up_o = 1'b0;
                dn_o = 1'b0;
            end
        endcase
    end

    always_comb begin
        AST_CAND_EXCL: assert (!(up_o && dn_o)) else $error("candidate up and down both set"); // R8
        AST_TOZERO_NO_UP: assert (!(mode_i == RM_TO_ZERO && up_o)) else $error("toward zero gave +1"); // R5
    end

endmodule

// File: rtl/sd_round_decide.sv
module sd_round_decide
    import sdr_pkg::*;
#(
    parameter int NPOS = 4
) (
    input  logic [NPOS-1:0] msd_i,
    input  logic [NPOS:0]   lsd_i,
    input  logic            gd_neg_i,
    input  logic            gd_pos_i,
    input  logic            rnd_bit_i,
    input  logic            st_neg_i,
    input  logic            st_pos_i,
    input  logic            ss_i,
    input  logic [1:0]      mode_i,
    input  logic            sign_i,
    output logic [NPOS-1:0] lead_o,
    output logic [NPOS:0]   loc_o,
    output logic            rnd_up_o,
    output logic            rnd_dn_o
);

    localparam int NLOC = NPOS + 1;

    logic [4:0]      tail;
    logic [NLOC-1:0] up_vec;
    logic [NLOC-1:0] dn_vec;
    rnd_mode_e       mode;

    assign tail = {gd_neg_i, gd_pos_i, rnd_bit_i, st_neg_i, st_pos_i};
    assign mode = rnd_mode_e'(mode_i);

    sdr_lead_detect #(.NPOS(NPOS)) i_lead (
        .msd_i  (msd_i),
        .ss_i   (ss_i),
        .lead_o (lead_o),
        .loc_o  (loc_o)
    );

    // Speculative decision at every candidate location
    generate
        for (genvar q = 0; q < NLOC; q++) begin : g_loc
            frac_cls_t cls;
            logic      lbit;

            sdr_frac_class #(.NPOS(NPOS), .LOC(q)) i_cls (
                .lsd_i  (lsd_i),
                .tail_i (tail),
                .cls_o  (cls),
                .lbit_o (lbit)
            );

            sdr_mode_decide i_dec (
                .cls_i  (cls),
                .lbit_i (lbit),
                .mode_i (mode),
                .sign_i (sign_i),
                .up_o   (up_vec[q]),
                .dn_o   (dn_vec[q])
            );
        end
    endgenerate

    // Late one-hot select
    assign rnd_up_o = |(loc_o & up_vec);
    assign rnd_dn_o = |(loc_o & dn_vec);

    always_comb begin
        AST_LOC_ONEHOT: assert ($onehot0(loc_o)) else $error("location not one-hot"); // R2
        AST_ZERO_MSD_QUIET: assert (msd_i != '0 || (loc_o == '0 && !rnd_up_o && !rnd_dn_o)) else $error("zero MSD produced output"); // R1
        AST_DM_AT_GUARD: assert (!(ss_i && msd_i == NPOS'(1)) || loc_o[0]) else $error("d-minus-one not at g0"); // R3
        AST_OUT_EXCL: assert (!(rnd_up_o && rnd_dn_o)) else $error("up and down both set"); // R8
        AST_DIRECTED_NO_GROW: assert (!(((mode == RM_TO_PLUS) && sign_i) || ((mode == RM_TO_MINUS) && !sign_i)) || !rnd_up_o) else $error("directed mode grew magnitude"); // R6
    end

endmodule

// File: tb/test_sd_round_decide.sv
module test_sd_round_decide;

    logic       clk = 1'b0;
    logic [3:0] msd = '0;
    logic [4:0] lsd = '0;
    logic       g1 = 1'b0, g0 = 1'b0, rb = 1'b0, s1 = 1'b0, s0 = 1'b0;
    logic       ss = 1'b0;
    logic [1:0] mode = '0;
    logic       sgn = 1'b0;
    logic [3:0] lead;
    logic [4:0] loc;
    logic       up, dn;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    logic [10:0] last_act;

    always #5 clk = ~clk;

    sd_round_decide i_sd_round_decide (
        .msd_i(msd), .lsd_i(lsd), .gd_neg_i(g1), .gd_pos_i(g0),
        .rnd_bit_i(rb), .st_neg_i(s1), .st_pos_i(s0), .ss_i(ss),
        .mode_i(mode), .sign_i(sgn), .lead_o(lead), .loc_o(loc),
        .rnd_up_o(up), .rnd_dn_o(dn)
    );

    // Behavioural model from the requirements, using real-valued weights
    function automatic logic [10:0] model(input logic [3:0] m, input logic [4:0] l,
                                          input logic [4:0] t, input logic s,
                                          input logic [1:0] md, input logic sg);
        int    lp = -1;
        int    p;
        real   below = 0.0;
        real   fr;
        real   w [9];
        int    pos [9];
        logic  bits [9];
        logic  lb;
        logic  eu = 0, ed = 0;
        logic [3:0] el = '0;
        logic [4:0] eloc = '0;
        for (int k = 0; k < 4; k++) if (lp < 0 && m[3-k]) lp = k;
        if (lp < 0) return 11'd0;
        el[3-lp] = 1'b1;
        p = lp + int'(s);
        eloc[4-p] = 1'b1;
        // f g h i g1 g0 r s1 s0
        w   = '{8.0, 4.0, 2.0, 1.0, -1.0, 0.5, 0.25, -0.25, 0.125};
        pos = '{0, 1, 2, 3, 4, 4, 5, 6, 6};
        bits = '{l[3], l[2], l[1], l[0], t[4], t[3], t[2], t[1], t[0]};
        for (int k = 0; k < 9; k++) if (pos[k] > p && bits[k]) below += w[k];
        fr = below / (2.0 ** (3 - p));
        lb = (p < 4) ? l[3-p] : t[3];
        case (md)
            2'b00: begin
                if (fr > 0.5) eu = 1;
                else if (fr == 0.5) eu = lb;
                else if (fr < -0.5) ed = 1;
                else if (fr == -0.5) ed = lb;
            end
            2'b01: ed = (fr < 0.0);
            default: begin
                if ((md == 2'b10) != sg) eu = (fr > 0.0);
                else ed = (fr < 0.0);
            end
        endcase
        return {el, eloc, eu, ed};
    endfunction

    task automatic apply(input string tag, input logic [3:0] m, input logic [4:0] l,
                         input logic [4:0] t, input logic s, input logic [1:0] md,
                         input logic sg);
        logic [10:0] exp_v, act_v;
        @(negedge clk);
        msd = m; lsd = l; {g1, g0, rb, s1, s0} = t; ss = s; mode = md; sgn = sg;
        #2;
        exp_v = model(m, l, t, s, md, sg);
        act_v = {lead, loc, up, dn};
        last_act = act_v;
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: act lead=%b loc=%b up=%b dn=%b exp lead=%b loc=%b up=%b dn=%b",
                     tag, act_v[10:7], act_v[6:2], act_v[1], act_v[0],
                     exp_v[10:7], exp_v[6:2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic same_as(input string tag, input logic [10:0] ref_v);
        checks++;
        if (last_act !== ref_v) begin
            fails++;
            $display("FAIL %s: act=%b exp=%b", tag, last_act, ref_v);
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=expired exp=complete");
            finish_run();
        end
    end

    initial begin
        logic [10:0] saved;
        // R1: zero MSD gives nothing
        apply("R1 zero msd", 4'b0000, 5'b01111, 5'b01101, 1'b0, 2'b00, 1'b0);
        apply("R1 zero msd ss", 4'b0000, 5'b10000, 5'b00000, 1'b1, 2'b01, 1'b0);
        // R2: locations without signed sticky
        apply("R2 lead a at f", 4'b1011, 5'b00000, 5'b00000, 1'b0, 2'b00, 1'b0);
        apply("R2 lead b at g", 4'b0100, 5'b00100, 5'b00000, 1'b0, 2'b00, 1'b0);
        apply("R2 lead c at h", 4'b0011, 5'b00011, 5'b00000, 1'b0, 2'b00, 1'b0);
        // R3: signed sticky lowers location
        apply("R3 dm at g0", 4'b0001, 5'b00000, 5'b01100, 1'b1, 2'b00, 1'b0);
        apply("R3 lead a to g", 4'b1000, 5'b00010, 5'b00000, 1'b1, 2'b00, 1'b0);
        // R4: nearest-even ties
        apply("R4 tie +L odd", 4'b1000, 5'b01100, 5'b00000, 1'b0, 2'b00, 1'b0);
        apply("R4 tie +L even", 4'b1000, 5'b00100, 5'b00000, 1'b0, 2'b00, 1'b0);
        apply("R4 tie -L odd", 4'b0001, 5'b00001, 5'b11000, 1'b0, 2'b00, 1'b0);
        apply("R4 tie -L even", 4'b0001, 5'b00000, 5'b11000, 1'b0, 2'b00, 1'b0);
        apply("R4 above half", 4'b0010, 5'b00001, 5'b00100, 1'b0, 2'b00, 1'b0);
        // R5: toward zero with negative fraction via g1
        apply("R5 neg frac", 4'b0001, 5'b00000, 5'b10001, 1'b0, 2'b01, 1'b0);
        apply("R5 pos frac", 4'b0001, 5'b00000, 5'b01000, 1'b0, 2'b01, 1'b1);
        // R6: directed modes
        apply("R6 plus pos", 4'b0100, 5'b00001, 5'b00000, 1'b0, 2'b10, 1'b0);
        apply("R6 plus neg", 4'b0001, 5'b00000, 5'b10100, 1'b0, 2'b10, 1'b1);
        apply("R6 minus neg", 4'b0100, 5'b00001, 5'b00000, 1'b0, 2'b11, 1'b1);
        apply("R6 minus pos", 4'b0001, 5'b00000, 5'b10100, 1'b0, 2'b11, 1'b0);
        // R7: g0 location
        apply("R7 g0 tie up", 4'b0001, 5'b00000, 5'b01100, 1'b1, 2'b00, 1'b0);
        apply("R7 g0 tie down", 4'b0001, 5'b00000, 5'b01010, 1'b1, 2'b00, 1'b0);
        apply("R7 g0 g1 ignored", 4'b0001, 5'b00000, 5'b10010, 1'b1, 2'b01, 1'b0);
        // R9: e bit and upper bits do not matter
        apply("R9 base", 4'b0010, 5'b00011, 5'b00001, 1'b0, 2'b00, 1'b0);
        saved = last_act;
        apply("R9 e flipped", 4'b0010, 5'b10011, 5'b00001, 1'b0, 2'b00, 1'b0);
        same_as("R9 e no effect", saved);
        apply("R9 f flipped", 4'b0010, 5'b01011, 5'b00001, 1'b0, 2'b00, 1'b0);
        same_as("R9 f no effect", saved);
        // R8 and R4 R5 R6: random sweep
        for (int n = 0; n < 20000; n++) begin
            apply("R8 R4 R5 R6 random", 4'($urandom), 5'($urandom), 5'($urandom),
                  1'($urandom), 2'($urandom), 1'($urandom));
            checks++;
            if (up && dn) begin
                fails++;
                $display("FAIL R8: act up=1 dn=1 exp exclusive");
            end
        end
        done = 1;
        finish_run();
    end

endmodule